// File: doc/BRIEF.md
# Smart Display Write Port

This block is the processor-facing side of a four-digit dot-matrix display controller. It takes a simple parallel bus (two active-low enables, an active-low write strobe, a store-select line, a two-bit digit address and a seven-bit data bus) and keeps the display's state in registers: one seven-bit character code per digit, two attribute bits per digit (cursor and blank-override) and one control word shared by all digits (master blank, three-bit brightness code, extended-function disable). The stored values come out as parallel signals for a refresh scanner and a blanking unit. Character codes are read through a combinational read port.

All bus inputs are brought into the system clock domain through a synchroniser. A write is committed once per rising edge of the write strobe, using the bus values sampled just before that edge. A clear input, also synchronised, is filtered by a cycle counter. Once it has been low long enough, it fills every character with the space code and zeroes all attribute and control bits, whatever the enables are doing.

Top module: `disp_write_port`

## Requirements
- R1: A write takes effect only if `ce1_n` and `ce2_n` were both 0 while the strobe was low. If either enable is 1, the stored values do not change.
- R2: With `sel_char`=1, the seven data bits are stored as the character of digit `addr`. Digit 0 is the rightmost and digit 3 the leftmost. The other digits keep their codes.
- R3: With `sel_char`=0, data bit 0 becomes the cursor bit of digit `addr` (`cursor_bits[addr]`) and data bit 1 becomes its blank-override bit (`blank_dis_bits[addr]`). The bits of the other digits and all character codes stay unchanged.
- R4: The same `sel_char`=0 write also loads the shared control word: data bit 2 into `master_blank`, bits 5..3 into `bright_code` (bit 3 is the LSB), and bit 6 into `ext_dis`.
- R5: An accepted clear sets every character code to 0x20 and every attribute and control bit to 0, whatever the values of `ce1_n` and `ce2_n`.
- R6: Clear is accepted only after the synchronised `clr_n` has been low for more than `CLR_CYCLES` consecutive clock cycles. A shorter low pulse changes nothing.
- R7: Each rising edge of `wr_n` causes exactly one write. That write uses the address, data, select and enable values present before the edge, so bus changes after the edge have no effect.
- R8: After `rst_n` the state is the same as after a clear: spaces in every digit and all bits 0.
- R9: `rd_char` shows the stored code of digit `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | First active-low enable |
| ce2_n | input | 1 | Second active-low enable |
| wr_n | input | 1 | Active-low write strobe; commit on its rising edge |
| sel_char | input | 1 | 1 = character store, 0 = attribute and control |
| addr | input | 2 | Digit address, 0 = rightmost |
| data | input | 7 | Write data |
| clr_n | input | 1 | Active-low clear, filtered by length |
| rd_addr | input | 2 | Character read address |
| rd_char | output | 7 | Character code at `rd_addr` |
| cursor_bits | output | 4 | Cursor bit per digit |
| blank_dis_bits | output | 4 | Blank-override bit per digit |
| master_blank | output | 1 | Shared master blank |
| bright_code | output | 3 | Shared brightness code |
| ext_dis | output | 1 | Shared extended-function disable |

## Verification
The assertions assume that the bus is quasi-static: the address, data, select and enables are held across each strobe low period and for at least one clock after its rise. This keeps the synchronised samples coherent. They also assume that a low time of one or more clock cycles is enough for every strobe pulse. The stimulus changes inputs only on falling clock edges. It keeps the write strobe low for three cycles, changes the data one cycle after the rise to probe the capture point, and holds clear either well below or well above the filter length.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  localparam int CODE_W = 7;
  localparam logic [CODE_W-1:0] SPACE_CODE = 7'h20;

  typedef struct packed {
    logic       efd;
    logic [2:0] bright;
    logic       mblank;
  } ctrl_t;

  // Control-field layout of an attribute/control write.
  function automatic ctrl_t ctrl_from_bus(input logic [CODE_W-1:0] d);
    ctrl_t c;
    c.efd    = d[6];
    c.bright = d[5:3];
    c.mblank = d[2];
    return c;
  endfunction

  function automatic logic digit_hit(input int unsigned idx, input int unsigned adr);
    return idx == adr;
  endfunction
endpackage

// File: rtl/dwp_bus_sync.sv
module dwp_bus_sync #(
  parameter int ADDR_W      = 2,
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              wr_n,
  input  logic              sel_char,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] data,
  output logic              wr_fire,
  output logic              wr_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CODE_W-1:0] wr_data
);
  // bus word: {ce1_n, ce2_n, wr_n, sel, addr, data}
  localparam int BW = 4 + ADDR_W + CODE_W;
  localparam logic [BW-1:0] IDLE = {3'b111, {(BW-3){1'b0}}};
  localparam int WR_BIT  = BW - 3;
  localparam int CE1_BIT = BW - 1;
  localparam int CE2_BIT = BW - 2;

  logic [BW-1:0] raw;
  logic [BW-1:0] stg [SYNC_STAGES+1];

  assign raw = {ce1_n, ce2_n, wr_n, sel_char, addr, data};

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stg[g] <= IDLE;
        else if (g == 0)
          stg[g] <= raw;
        else
          stg[g] <= stg[g-1];
      end
    end
  endgenerate

  // stg[SYNC_STAGES] holds the sample before the synchronised strobe edge
  logic [BW-1:0] cur, prv;
  assign cur = stg[SYNC_STAGES-1];
  assign prv = stg[SYNC_STAGES];

  assign wr_fire = !prv[WR_BIT] && cur[WR_BIT] && !prv[CE1_BIT] && !prv[CE2_BIT];
  assign wr_sel  = prv[CODE_W+ADDR_W];
  assign wr_addr = prv[CODE_W +: ADDR_W];
  assign wr_data = prv[CODE_W-1:0];
endmodule

// File: rtl/dwp_clear_filter.sv
module dwp_clear_filter #(
  parameter int CLR_CYCLES  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clr_apply
);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CLR_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;
  logic                   clr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], clr_n};
  end
  assign clr_s = sync_q[SYNC_STAGES-1];

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == LIMIT) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (clr_s) low_cnt <= '0;
    else            low_cnt <= sat_inc(low_cnt);
  end

  assign clr_apply = !clr_s && (low_cnt == LIMIT);
endmodule

// File: rtl/dwp_store.sv
module dwp_store
  import dwp_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_apply,
  input  logic                     wr_fire,
  input  logic                     wr_sel,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [CODE_W-1:0]        rd_char,
  output logic [DIGITS*CODE_W-1:0] char_flat,
  output logic [DIGITS-1:0]        cursor_q,
  output logic [DIGITS-1:0]        bdis_q,
  output ctrl_t                    ctrl_q
);
  logic [CODE_W-1:0] char_q [DIGITS];
  logic              char_we, attr_we;

  assign char_we = wr_fire &&  wr_sel && !clr_apply;
  assign attr_we = wr_fire && !wr_sel && !clr_apply;

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          char_q[d] <= SPACE_CODE;
        else if (clr_apply)
          char_q[d] <= SPACE_CODE;
        else if (char_we && digit_hit(d, wr_addr))
          char_q[d] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cursor_q[d] <= 1'b0;
          bdis_q[d]   <= 1'b0;
        end else if (clr_apply) begin
          cursor_q[d] <= 1'b0;
          bdis_q[d]   <= 1'b0;
        end else if (attr_we && digit_hit(d, wr_addr)) begin
          cursor_q[d] <= wr_data[0];
          bdis_q[d]   <= wr_data[1];
        end
      end

      assign char_flat[d*CODE_W +: CODE_W] = char_q[d];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (clr_apply) ctrl_q <= '0;
    else if (attr_we)   ctrl_q <= ctrl_from_bus(wr_data);
  end

  assign rd_char = char_q[rd_addr];
endmodule

// File: rtl/disp_write_port.sv
module disp_write_port
  import dwp_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int CLR_CYCLES  = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              wr_n,
  input  logic              sel_char,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] data,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CODE_W-1:0] rd_char,
  output logic [DIGITS-1:0] cursor_bits,
  output logic [DIGITS-1:0] blank_dis_bits,
  output logic              master_blank,
  output logic [2:0]        bright_code,
  output logic              ext_dis
);
  // named internal events, observed by the checker
  logic                     wr_fire;
  logic                     wr_sel;
  logic [ADDR_W-1:0]        wr_addr;
  logic [CODE_W-1:0]        wr_data;
  logic                     clr_apply;
  logic [DIGITS*CODE_W-1:0] char_flat;
  ctrl_t                    ctrl_q;

  dwp_bus_sync #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .wr_n(wr_n),
    .sel_char(sel_char), .addr(addr), .data(data),
    .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  dwp_clear_filter #(.CLR_CYCLES(CLR_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_apply(clr_apply)
  );

  dwp_store #(.DIGITS(DIGITS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_apply(clr_apply),
    .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_char(rd_char), .char_flat(char_flat),
    .cursor_q(cursor_bits), .bdis_q(blank_dis_bits), .ctrl_q(ctrl_q)
  );

  assign master_blank = ctrl_q.mblank;
  assign bright_code  = ctrl_q.bright;
  assign ext_dis      = ctrl_q.efd;
endmodule

// File: rtl/dwp_checker.sv
module dwp_checker #(
  parameter int DIGITS = 4,
  parameter int ADDR_W = 2,
  parameter int CODE_W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_fire,
  input logic                     wr_sel,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [CODE_W-1:0]        wr_data,
  input logic                     clr_apply,
  input logic [DIGITS*CODE_W-1:0] char_flat,
  input logic [DIGITS-1:0]        cursor_bits,
  input logic [DIGITS-1:0]        blank_dis_bits,
  input logic                     master_blank,
  input logic [2:0]               bright_code,
  input logic                     ext_dis
);
  p_char_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_sel && !clr_apply) |=>
      char_flat[$past(wr_addr)*CODE_W +: CODE_W] == $past(wr_data));

  p_attr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_sel && !clr_apply) |=>
      (cursor_bits[$past(wr_addr)] == $past(wr_data[0])) &&
      (blank_dis_bits[$past(wr_addr)] == $past(wr_data[1])) &&
      $stable(char_flat));

  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_sel && !clr_apply) |=>
      {ext_dis, bright_code, master_blank} == $past(wr_data[6:2]));

  p_no_write_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !clr_apply) |=>
      $stable(char_flat) && $stable(cursor_bits) && $stable(blank_dis_bits) &&
      $stable({ext_dis, bright_code, master_blank}));

  p_clear_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_apply |=>
      (char_flat == {DIGITS{7'h20}}) && (cursor_bits == '0) && (blank_dis_bits == '0) &&
      ({ext_dis, bright_code, master_blank} == 5'b0));

  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

bind disp_write_port dwp_checker #(.DIGITS(DIGITS), .ADDR_W(ADDR_W), .CODE_W(dwp_pkg::CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_addr(wr_addr),
  .wr_data(wr_data), .clr_apply(clr_apply), .char_flat(char_flat),
  .cursor_bits(cursor_bits), .blank_dis_bits(blank_dis_bits),
  .master_blank(master_blank), .bright_code(bright_code), .ext_dis(ext_dis)
);

// File: tb/tb_disp_write_port.sv
module tb_disp_write_port;
  localparam int CLR = 16;
  localparam int NV  = 12;
  // vector: {ce1_n, ce2_n, sel_char, addr[1:0], data[6:0]}
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b1, 2'd0, 7'h41},
    {2'b00, 1'b1, 2'd3, 7'h5A},
    {2'b00, 1'b1, 2'd1, 7'h30},
    {2'b00, 1'b1, 2'd2, 7'h7F},
    {2'b10, 1'b1, 2'd0, 7'h11},
    {2'b01, 1'b1, 2'd3, 7'h22},
    {2'b00, 1'b0, 2'd1, 7'h5F},
    {2'b00, 1'b0, 2'd2, 7'h29},
    {2'b11, 1'b0, 2'd0, 7'h7F},
    {2'b00, 1'b0, 2'd1, 7'h02},
    {2'b00, 1'b1, 2'd1, 7'h20},
    {2'b00, 1'b0, 2'd3, 7'h01}
  };

  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2_n = 1, wr_n = 1, sel_char = 0, clr_n = 1;
  logic [1:0] addr = 0, rd_addr = 0;
  logic [6:0] data = 0;
  logic [6:0] rd_char;
  logic [3:0] cursor_bits, blank_dis_bits;
  logic master_blank, ext_dis;
  logic [2:0] bright_code;

  int checks = 0, fails = 0;
  logic [6:0] m_char [4];
  logic [3:0] m_cur, m_bd;
  logic [4:0] m_ctrl; // {ext_dis, bright, master_blank}

  always #5 clk = ~clk;

  disp_write_port #(.CLR_CYCLES(CLR)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .wr_n(wr_n),
    .sel_char(sel_char), .addr(addr), .data(data), .clr_n(clr_n),
    .rd_addr(rd_addr), .rd_char(rd_char), .cursor_bits(cursor_bits),
    .blank_dis_bits(blank_dis_bits), .master_blank(master_blank),
    .bright_code(bright_code), .ext_dis(ext_dis)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_char[i] = 7'h20;
    m_cur = 0; m_bd = 0; m_ctrl = 0;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_addr = 2'(i);
      #1;
      chk({tag, " R9 char"}, int'(rd_char), int'(m_char[i]));
    end
    chk({tag, " cursor"}, int'(cursor_bits), int'(m_cur));
    chk({tag, " blankdis"}, int'(blank_dis_bits), int'(m_bd));
    chk({tag, " ctrl"}, int'({ext_dis, bright_code, master_blank}), int'(m_ctrl));
  endtask

  task automatic do_write(input logic [11:0] v);
    @(negedge clk);
    {ce1_n, ce2_n, sel_char, addr, data} = v;
    wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    data = data ^ 7'h7F;   // R7: change after the rising edge must not matter
    sel_char = ~sel_char;
    repeat (4) @(negedge clk);
    ce1_n = 1; ce2_n = 1;
    if (!v[11] && !v[10]) begin
      if (v[9]) m_char[v[8:7]] = v[6:0];
      else begin
        m_cur[v[8:7]] = v[0];
        m_bd[v[8:7]]  = v[1];
        m_ctrl        = v[6:2];
      end
    end
  endtask

  task automatic pulse_clear(input int len);
    @(negedge clk);
    clr_n = 0;
    ce1_n = 1; ce2_n = 1;
    repeat (len) @(negedge clk);
    clr_n = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R8 reset state");

    // R1 R2 R3 R4 R7 vector walk
    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k]);
      check_all($sformatf("R1 R2 R3 R4 R7 vec%0d", k));
    end

    // R6: short clear pulse leaves contents intact
    pulse_clear(CLR - 4);
    check_all("R6 short clear ignored");

    // R5: long clear with enables high restores spaces and zeros
    pulse_clear(CLR + 6);
    model_clear();
    check_all("R5 clear");

    // R2: writes after clear in reverse address order
    for (int i = 3; i >= 0; i--) do_write({2'b00, 1'b1, 2'(i), 7'(7'h61 + i)});
    check_all("R2 post-clear order");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule